// File: doc/BRIEF.md
# Real-Mode Segmented Address Generator

This block turns a 16-bit offset into a 20-bit physical address the way a 16-bit real-mode processor does. It holds no segment state of its own. Each cycle it is given the current code, data, stack and extra segment values, the offset, the kind of access and the base register the offset came from. It may also be given a segment override.

The block picks the segment that the access should use and multiplies it by sixteen. It adds the offset and drops any carry beyond bit 19, so the address wraps inside 1 MB. One cycle after each valid request it presents the address, a valid strobe and a 2-bit code that names the segment used. Different segment:offset pairs can land on the same physical byte, and the block makes no attempt to tell them apart.

Top module: `rm_addr_gen`

## Requirements
- R1: The address equals (segment << 4) + offset. Any carry out of bit 19 is dropped, so FFFF:0020 yields 00010h.
- R2: An instruction fetch (`acc_kind` = 0) always uses the code segment. The base select and the override are ignored for it.
- R3: A data access (`acc_kind` = 1 or 3) with no valid override and base select 4 (BP) or 5 (SP) uses the stack segment.
- R4: A data access with no valid override and any other base select uses the data segment. The other codes are 0 (direct reference), 1 (BX), 2 (SI), 3 (DI), 6 and 7.
- R5: A string destination access (`acc_kind` = 2) always uses the extra segment, even when an override is valid.
- R6: On a data access, when `ovr_valid` is 1, the segment named by `ovr_seg` replaces the default segment.
- R7: `out_valid` follows `req_valid` with exactly one cycle of delay. While no request is made, `phys_addr` and `seg_used` hold their last values.
- R8: Segments are named by the same 2-bit code on `ovr_seg` and on `seg_used`: 0 = extra, 1 = code, 2 = stack, 3 = data.
- R9: After a synchronous active-low reset, `out_valid`, `phys_addr` and `seg_used` are all zero.
- R10: Aliased pairs give the same address. 0810:0000 and 0800:0100 both give 08100h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| acc_kind | input | 2 | Access kind: 0 fetch, 1 data, 2 string destination, 3 data |
| base_sel | input | 3 | Base register of the offset: 0 direct, 1 BX, 2 SI, 3 DI, 4 BP, 5 SP |
| ovr_valid | input | 1 | Segment override requested |
| ovr_seg | input | 2 | Override segment code |
| seg_code_val | input | 16 | Code segment value |
| seg_data_val | input | 16 | Data segment value |
| seg_stack_val | input | 16 | Stack segment value |
| seg_extra_val | input | 16 | Extra segment value |
| offset | input | 16 | Offset within the segment |
| out_valid | output | 1 | Result valid |
| phys_addr | output | 20 | Physical address |
| seg_used | output | 2 | Code of the segment used |

## Verification
The bench builds the block with its default parameters: 16-bit segments and offsets and a 4-bit shift. With these values the 20-bit wrap can be reached from real segment values. An extra segment of FFFFh combined with a large offset drives the sum past bit 19. That exercises the dropped carry and, in the same vectors, the string destination path. With full-width 16-bit segments, distinct segment:offset pairs can also be placed on one physical address to check aliasing.

// File: rtl/rm_addr_pkg.sv
// Package: shared encodings for the real-mode address generator.
// Assumes: 2-bit segment codes and access kinds are fixed by the block's ports.
package rm_addr_pkg;

    // Segment identity, as reported on seg_used and accepted on ovr_seg
    typedef enum logic [1:0] {
        SEG_EXTRA = 2'd0,
        SEG_CODE  = 2'd1,
        SEG_STACK = 2'd2,
        SEG_DATA  = 2'd3
    } seg_id_e;

    // Kind of memory access
    typedef enum logic [1:0] {
        ACC_FETCH   = 2'd0,
        ACC_DATA    = 2'd1,
        ACC_STR_DST = 2'd2,
        ACC_DATA_X  = 2'd3
    } acc_kind_e;

    // Base register the offset was taken from
    localparam logic [2:0] BASE_DIRECT = 3'd0;
    localparam logic [2:0] BASE_BX     = 3'd1;
    localparam logic [2:0] BASE_SI     = 3'd2;
    localparam logic [2:0] BASE_DI     = 3'd3;
    localparam logic [2:0] BASE_BP     = 3'd4;
    localparam logic [2:0] BASE_SP     = 3'd5;

endpackage

// File: rtl/rm_seg_select.sv
// Module: picks the segment for one access and returns its value and code.
// Assumes: purely combinational; fetches are pinned to the code segment and
// string destinations to the extra segment, and only data accesses honour an override.
module rm_seg_select
    import rm_addr_pkg::*;
#(
    parameter int SEG_W = 16
) (
    input  logic [1:0]       acc_kind,
    input  logic [2:0]       base_sel,
    input  logic             ovr_valid,
    input  logic [1:0]       ovr_seg,
    input  logic [SEG_W-1:0] seg_code_val,
    input  logic [SEG_W-1:0] seg_data_val,
    input  logic [SEG_W-1:0] seg_stack_val,
    input  logic [SEG_W-1:0] seg_extra_val,
    output logic [1:0]       sel_code,
    output logic [SEG_W-1:0] sel_val
);

    seg_id_e pick;

    // Choose the segment identity from access kind, override and base register
    always_comb begin
        case (acc_kind_e'(acc_kind))
            ACC_FETCH:   pick = SEG_CODE;
            ACC_STR_DST: pick = SEG_EXTRA;
            default: begin
                if (ovr_valid)
                    pick = seg_id_e'(ovr_seg);
                else if (base_sel == BASE_BP || base_sel == BASE_SP)
                    pick = SEG_STACK;
                else
                    pick = SEG_DATA;
            end
        endcase
    end

    // Route the chosen segment register value
    always_comb begin
        case (pick)
            SEG_EXTRA: sel_val = seg_extra_val;
            SEG_CODE:  sel_val = seg_code_val;
            SEG_STACK: sel_val = seg_stack_val;
            default:   sel_val = seg_data_val;
        endcase
    end

    assign sel_code = pick;

endmodule

// File: rtl/rm_addr_adder.sv
// Module: forms segment * 2**SHIFT + offset, truncated to the address width.
// Assumes: OFF_W <= SEG_W + SHIFT; the carry beyond the top address bit is discarded.
module rm_addr_adder #(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4
) (
    input  logic [SEG_W-1:0]       seg_val,
    input  logic [OFF_W-1:0]       off_val,
    output logic [SEG_W+SHIFT-1:0] addr
);

    localparam int ADDR_W = SEG_W + SHIFT;
    localparam int PAD_W  = ADDR_W + 1 - OFF_W;

    logic [ADDR_W:0] sum;

    // Wide add with one spare bit, then drop the carry to wrap the space
    always_comb begin
        sum  = {1'b0, seg_val, {SHIFT{1'b0}}} + {{PAD_W{1'b0}}, off_val};
        addr = sum[ADDR_W-1:0];
    end

    // The low bits below the shift come straight from the offset
    always_comb begin
        assert_low_bits_R1: assert (addr[SHIFT-1:0] == off_val[SHIFT-1:0]);
    end

endmodule

// File: rtl/rm_addr_gen.sv
// Module: top of the real-mode address generator; one register stage
// captures address and segment code on each valid request.
// Assumes: synchronous active-low reset; outputs hold between requests.
module rm_addr_gen
    import rm_addr_pkg::*;
#(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [1:0]             acc_kind,
    input  logic [2:0]             base_sel,
    input  logic                   ovr_valid,
    input  logic [1:0]             ovr_seg,
    input  logic [SEG_W-1:0]       seg_code_val,
    input  logic [SEG_W-1:0]       seg_data_val,
    input  logic [SEG_W-1:0]       seg_stack_val,
    input  logic [SEG_W-1:0]       seg_extra_val,
    input  logic [OFF_W-1:0]       offset,
    output logic                   out_valid,
    output logic [SEG_W+SHIFT-1:0] phys_addr,
    output logic [1:0]             seg_used
);

    localparam int ADDR_W = SEG_W + SHIFT;

    logic [1:0]        nxt_code;
    logic [SEG_W-1:0]  nxt_seg;
    logic [ADDR_W-1:0] nxt_addr;

    rm_seg_select #(.SEG_W(SEG_W)) u_sel (
        .acc_kind      (acc_kind),
        .base_sel      (base_sel),
        .ovr_valid     (ovr_valid),
        .ovr_seg       (ovr_seg),
        .seg_code_val  (seg_code_val),
        .seg_data_val  (seg_data_val),
        .seg_stack_val (seg_stack_val),
        .seg_extra_val (seg_extra_val),
        .sel_code      (nxt_code),
        .sel_val       (nxt_seg)
    );

    rm_addr_adder #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_add (
        .seg_val (nxt_seg),
        .off_val (offset),
        .addr    (nxt_addr)
    );

    // Output register: strobe every cycle, data only on a request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            phys_addr <= '0;
            seg_used  <= 2'd0;
        end else begin
            out_valid <= req_valid;
            if (req_valid) begin
                phys_addr <= nxt_addr;
                seg_used  <= nxt_code;
            end
        end
    end

    // Strobe latency is one cycle
    assert_valid_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);
    assert_no_spurious_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);
    // Outputs hold while idle
    assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(phys_addr) && $stable(seg_used)));
    // Fetch always reports the code segment
    assert_fetch_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && acc_kind == 2'd0) |=> (seg_used == 2'd1));
    // String destination always reports the extra segment
    assert_strdst_extra_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && acc_kind == 2'd2) |=> (seg_used == 2'd0));
    // Stack-based data without override reports the stack segment
    assert_stack_base_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && acc_kind[0] && !ovr_valid && (base_sel == 3'd4 || base_sel == 3'd5))
        |=> (seg_used == 2'd2));
    // A valid override on a data access is reported as the segment used
    assert_override_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && acc_kind[0] && ovr_valid) |=> (seg_used == $past(ovr_seg)));

endmodule

// File: tb/tb_rm_addr_gen.sv
module tb_rm_addr_gen;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [1:0]  acc_kind;
    logic [2:0]  base_sel;
    logic        ovr_valid;
    logic [1:0]  ovr_seg;
    logic [15:0] seg_code_val, seg_data_val, seg_stack_val, seg_extra_val;
    logic [15:0] offset;
    logic        out_valid;
    logic [19:0] phys_addr;
    logic [1:0]  seg_used;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    rm_addr_gen dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .acc_kind(acc_kind),
        .base_sel(base_sel), .ovr_valid(ovr_valid), .ovr_seg(ovr_seg),
        .seg_code_val(seg_code_val), .seg_data_val(seg_data_val),
        .seg_stack_val(seg_stack_val), .seg_extra_val(seg_extra_val),
        .offset(offset), .out_valid(out_valid), .phys_addr(phys_addr),
        .seg_used(seg_used)
    );

    // Vector: kind(2) base(3) ovr_v(1) ovr_seg(2) offset(16) exp_addr(20) exp_seg(2)
    // Segments: code 1000h, data 0800h, stack 3000h, extra FFFFh
    localparam int NV = 11;
    localparam logic [45:0] VECS [NV] = '{
        {2'd0, 3'd0, 1'b0, 2'd0, 16'h0100, 20'h10100, 2'd1},  // R2 fetch
        {2'd0, 3'd4, 1'b1, 2'd0, 16'h0234, 20'h10234, 2'd1},  // R2 fetch ignores override
        {2'd1, 3'd1, 1'b0, 2'd0, 16'h0100, 20'h08100, 2'd3},  // R4 BX
        {2'd1, 3'd4, 1'b0, 2'd0, 16'h0010, 20'h30010, 2'd2},  // R3 BP
        {2'd1, 3'd5, 1'b0, 2'd0, 16'hFFFE, 20'h3FFFE, 2'd2},  // R3 SP
        {2'd1, 3'd0, 1'b1, 2'd0, 16'h0020, 20'h00010, 2'd0},  // R6 R1 wrap
        {2'd2, 3'd3, 1'b1, 2'd1, 16'h0005, 20'hFFFF5, 2'd0},  // R5 ignores override
        {2'd1, 3'd2, 1'b0, 2'd0, 16'hABCD, 20'h12BCD, 2'd3},  // R4 SI
        {2'd1, 3'd3, 1'b0, 2'd0, 16'h0001, 20'h08001, 2'd3},  // R4 DI non-string
        {2'd3, 3'd4, 1'b1, 2'd3, 16'h0040, 20'h08040, 2'd3},  // R6 kind 3 override
        {2'd1, 3'd7, 1'b0, 2'd0, 16'h0002, 20'h08002, 2'd3}   // R4 code 7
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One request, checked after the capturing edge
    task automatic issue(input logic [1:0] k, input logic [2:0] b, input logic ov,
                         input logic [1:0] os, input logic [15:0] off,
                         input logic [19:0] ea, input logic [1:0] es, input string req);
        @(negedge clk);
        req_valid = 1'b1; acc_kind = k; base_sel = b;
        ovr_valid = ov; ovr_seg = os; offset = off;
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " valid"}, {31'd0, out_valid}, 32'd1);
        check({req, " addr"}, {12'd0, phys_addr}, {12'd0, ea});
        check({req, " seg"}, {30'd0, seg_used}, {30'd0, es});
    endtask

    initial begin
        #3_000_000;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; acc_kind = 2'd0; base_sel = 3'd0;
        ovr_valid = 1'b0; ovr_seg = 2'd0; offset = 16'h0;
        seg_code_val = 16'h1000; seg_data_val = 16'h0800;
        seg_stack_val = 16'h3000; seg_extra_val = 16'hFFFF;
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 valid", {31'd0, out_valid}, 32'd0);
        check("R9 addr", {12'd0, phys_addr}, 32'd0);
        check("R9 seg", {30'd0, seg_used}, 32'd0);
        rst_n = 1'b1;

        // Table walk, R1 and R8 apply to every row
        for (int i = 0; i < NV; i++) begin
            issue(VECS[i][45:44], VECS[i][43:41], VECS[i][40], VECS[i][39:38],
                  VECS[i][37:22], VECS[i][21:2], VECS[i][1:0], $sformatf("R1/R8 vec%0d", i));
        end

        // R7 hold: idle cycle with changed inputs
        @(negedge clk);
        acc_kind = 2'd0; offset = 16'h7777; seg_code_val = 16'h2222;
        @(negedge clk);
        check("R7 idle valid", {31'd0, out_valid}, 32'd0);
        check("R7 idle addr hold", {12'd0, phys_addr}, 32'h08002);
        check("R7 idle seg hold", {30'd0, seg_used}, 32'd3);
        seg_code_val = 16'h1000;

        // R10 alias: 0810:0000 equals 0800:0100
        seg_data_val = 16'h0810;
        issue(2'd1, 3'd1, 1'b0, 2'd0, 16'h0000, 20'h08100, 2'd3, "R10 alias");
        seg_data_val = 16'h0800;

        // R1 maximal wrap on string destination, R5
        issue(2'd2, 3'd3, 1'b0, 2'd0, 16'hFFFF, 20'h0FFEF, 2'd0, "R1 R5 max wrap");

        // R6 override to stack on direct reference
        issue(2'd1, 3'd0, 1'b1, 2'd2, 16'h0003, 20'h30003, 2'd2, "R6 ovr stack");

        // R7 back-to-back requests
        @(negedge clk);
        req_valid = 1'b1; acc_kind = 2'd0; base_sel = 3'd0; ovr_valid = 1'b0; offset = 16'h0001;
        @(negedge clk);
        check("R7 b2b first", {12'd0, phys_addr}, 32'h10001);
        acc_kind = 2'd1; base_sel = 3'd4; offset = 16'h0002;
        @(negedge clk);
        req_valid = 1'b0;
        check("R7 b2b second", {12'd0, phys_addr}, 32'h30002);
        check("R7 b2b valid", {31'd0, out_valid}, 32'd1);
        @(negedge clk);
        check("R7 drop valid", {31'd0, out_valid}, 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule